// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the front of a receive path and decides, frame by frame, whether the frame should be kept. The destination address of each frame enters as six bytes, one byte per cycle in which `rx_byte_vld` is high, and the frame closes with a one-cycle `rx_frame_end` strobe. The bytes are compared on the fly against a 48-bit station address held in six byte-wide registers, and against the all-ones broadcast address. One cycle after the sixth byte, the block raises exactly one of `accept` or `reject` for a single cycle.

A 2-bit accept mode picks the policy. Mode 0 takes nothing. Mode 1 takes only an exact station match. Mode 2 takes a station match or a broadcast. Mode 3 takes every frame that has a full address. The mode is sampled when a frame's first byte arrives, so a change made during a frame takes effect from the next frame. A frame whose end marker comes before its sixth byte is rejected. Bytes after the sixth are ignored until the end marker.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `accept` and `reject` are low, and all six station bytes are 0x00, so in mode 1 a destination of 00:00:00:00:00:00 is accepted.
- R2: A write with `cfg_we` high loads `cfg_wdata` into station byte `cfg_addr` (0 to 5). The first destination byte received is compared with station byte 0, the second with byte 1, and so on.
- R3: In mode 0 (`acc_mode` = 2'b00), every frame gets `reject`.
- R4: In mode 1 (2'b01), a frame is accepted only if all six destination bytes equal the station bytes. A mismatch in any single byte, including a broadcast destination when the station address is not all ones, gives `reject`.
- R5: In mode 2 (2'b10), a frame is accepted if it matches the station address or if all six destination bytes are 0xFF. Otherwise it is rejected.
- R6: In mode 3 (2'b11), every frame with at least six address bytes is accepted.
- R7: For each frame, exactly one decision pulse is raised. It is one cycle wide and appears in the cycle after the sixth byte is taken. `accept` and `reject` are never high together.
- R8: If the end marker arrives before the sixth byte, `reject` is raised in the cycle after the end marker, in every mode including mode 3. An end marker with no bytes before it counts as such a short frame.
- R9: Bytes taken after the sixth byte of a frame produce no further decision. The block waits for the end marker before it starts a new frame.
- R10: The accept mode is sampled together with the first byte of a frame. A change of `acc_mode` later in the same frame does not affect that frame's decision, and it does apply to the next frame.
- R11: Cycles in which `rx_byte_vld` is low do not count as bytes. The decision follows the sixth valid byte however far apart the bytes are spread.
- R12: An end marker in the same cycle as a byte makes that byte the last one of the frame. If it is the sixth byte, the normal decision is raised, and the next byte starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Station byte write strobe |
| cfg_addr | input | 3 | Station byte index (0 to 5) |
| cfg_wdata | input | 8 | Station byte write value |
| acc_mode | input | 2 | Accept mode: 0 none, 1 station, 2 station or broadcast, 3 all |
| rx_byte_vld | input | 1 | Destination byte strobe |
| rx_byte | input | 8 | Destination byte, first byte first |
| rx_frame_end | input | 1 | End-of-frame marker |
| accept | output | 1 | One-cycle pulse: frame accepted |
| reject | output | 1 | One-cycle pulse: frame rejected |

## Verification
A table of frames runs every mode against several destinations: an exact match, the broadcast address, a copy with only the first or only the last byte changed, a byte-reversed copy of the station address, an address that is all ones except for its final bit, and an unrelated address. Together these separate a full six-byte comparison from a partial one, show that byte order is respected, and show that broadcast detection needs every bit set. Directed frames then cover the reset contents of the station registers, short and empty frames, trailing bytes, idle gaps between bytes, an end marker that arrives with the sixth byte, and a mode change in the middle of a frame in both directions. Each frame's decision is sampled in the exact cycle it is due and again in the cycle after, so a late, early or stretched pulse is caught.

// File: rtl/afilt_pkg.sv
// Package: shared types for the receive address filter.
// Assumes: accept mode encoding is fixed at 2 bits and never extended.
package afilt_pkg;

    // Accept policy, encoding is part of the block's contract.
    typedef enum logic [1:0] {
        ACC_NONE      = 2'd0,
        ACC_STATION   = 2'd1,
        ACC_STA_BCAST = 2'd2,
        ACC_ALL       = 2'd3
    } acc_mode_e;

    // Frame tracking state.
    typedef enum logic [1:0] {
        TRK_IDLE    = 2'd0,
        TRK_COLLECT = 2'd1,
        TRK_HOLD    = 2'd2
    } trk_state_e;

endpackage

// File: rtl/afilt_station_regs.sv
// Module: station address register file.
// Holds one byte register per address byte; a write to an index outside the
// register range is dropped. Assumes cfg_addr is stable with cfg_we.
module afilt_station_regs #(
    parameter int BYTES  = 6,
    parameter int BYTE_W = 8,
    localparam int AW    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_idx,
    input  logic [BYTE_W-1:0]             wr_val,
    output logic [BYTES-1:0][BYTE_W-1:0]  sta_bytes
);

    for (genvar k = 0; k < BYTES; k++) begin : g_reg
        logic [BYTE_W-1:0] byte_q;

        // Load station byte k on a matching write, clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_idx == AW'(k))) begin
                byte_q <= wr_val;
            end
        end

        assign sta_bytes[k] = byte_q;
    end

endmodule

// File: rtl/afilt_frame_track.sv
// Module: frame position tracker.
// Counts valid address bytes, flags the first and the last address byte and
// an early end marker, and holds off until the end marker once the address
// is complete. Assumes rx_frame_end is a one-cycle strobe.
module afilt_frame_track
    import afilt_pkg::*;
#(
    parameter int BYTES = 6,
    localparam int CW   = $clog2(BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic          frame_end,
    output logic          byte_take,
    output logic          first_byte,
    output logic          last_byte,
    output logic          end_early,
    output logic [CW-1:0] byte_idx
);

    trk_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          open_w;

    assign open_w     = (state_q != TRK_HOLD);
    assign byte_take  = open_w && byte_vld;
    assign first_byte = byte_take && (state_q == TRK_IDLE);
    assign last_byte  = byte_take && (cnt_q == CW'(BYTES - 1));
    assign end_early  = open_w && frame_end && !last_byte;
    assign byte_idx   = cnt_q;

    // Next-state and next-count selection for the frame position.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TRK_IDLE, TRK_COLLECT: begin
                if (last_byte) begin
                    cnt_d   = '0;
                    state_d = frame_end ? TRK_IDLE : TRK_HOLD;
                end else if (frame_end) begin
                    cnt_d   = '0;
                    state_d = TRK_IDLE;
                end else if (byte_take) begin
                    cnt_d   = cnt_q + 1'b1;
                    state_d = TRK_COLLECT;
                end
            end
            TRK_HOLD: begin
                if (frame_end) begin
                    state_d = TRK_IDLE;
                end
            end
            default: begin
                state_d = TRK_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Register the frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/afilt_match.sv
// Module: running destination comparator.
// Keeps two flags per frame: still equal to the station address, and still
// all ones. The flags include the byte in flight so the last byte needs no
// extra cycle. Assumes byte_idx is below BYTES whenever byte_take is high.
module afilt_match #(
    parameter int BYTES  = 6,
    parameter int BYTE_W = 8,
    localparam int CW    = $clog2(BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_take,
    input  logic                          first_byte,
    input  logic [CW-1:0]                 byte_idx,
    input  logic [BYTE_W-1:0]             byte_in,
    input  logic [BYTES-1:0][BYTE_W-1:0]  sta_bytes,
    output logic                          sta_hit,
    output logic                          bc_hit
);

    localparam logic [BYTE_W-1:0] ALL_ONES = '1;

    logic              sta_q, bc_q;
    logic              sta_base, bc_base;
    logic [BYTE_W-1:0] ref_byte;

    // Select the station byte that lines up with the incoming byte.
    always_comb begin
        ref_byte = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (byte_idx == CW'(k)) begin
                ref_byte = sta_bytes[k];
            end
        end
    end

    assign sta_base = first_byte ? 1'b1 : sta_q;
    assign bc_base  = first_byte ? 1'b1 : bc_q;
    assign sta_hit  = sta_base && (byte_in == ref_byte);
    assign bc_hit   = bc_base && (byte_in == ALL_ONES);

    // Carry both match flags from byte to byte within a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sta_q <= 1'b0;
            bc_q  <= 1'b0;
        end else if (byte_take) begin
            sta_q <= sta_hit;
            bc_q  <= bc_hit;
        end
    end

endmodule

// File: rtl/afilt_decide.sv
// Module: accept policy and decision register.
// Samples the mode with a frame's first byte and turns the match flags into
// a one-cycle accept or reject pulse. Assumes last_byte and end_early are
// never high together.
module afilt_decide
    import afilt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    input  logic       first_byte,
    input  logic       last_byte,
    input  logic       end_early,
    input  logic       sta_hit,
    input  logic       bc_hit,
    output acc_mode_e  mode_use,
    output logic       accept,
    output logic       reject
);

    acc_mode_e mode_q;
    logic      pass_w;
    logic      acc_q, rej_q;

    assign mode_use = first_byte ? acc_mode_e'(mode_in) : mode_q;

    // Apply the frame's policy to the final match flags.
    always_comb begin
        unique case (mode_use)
            ACC_NONE:      pass_w = 1'b0;
            ACC_STATION:   pass_w = sta_hit;
            ACC_STA_BCAST: pass_w = sta_hit || bc_hit;
            ACC_ALL:       pass_w = 1'b1;
            default:       pass_w = 1'b0;
        endcase
    end

    // Hold the mode sampled at the start of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ACC_NONE;
        end else if (first_byte) begin
            mode_q <= acc_mode_e'(mode_in);
        end
    end

    // Register the single-cycle decision pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= 1'b0;
            rej_q <= 1'b0;
        end else begin
            acc_q <= last_byte && pass_w;
            rej_q <= (last_byte && !pass_w) || end_early;
        end
    end

    assign accept = acc_q;
    assign reject = rej_q;

endmodule

// File: rtl/rx_addr_filter.sv
// Module: receive destination address filter, top level.
// Ties the station registers, frame tracker, comparator and policy together.
// Assumes destination bytes arrive first byte first, one per valid strobe.
module rx_addr_filter
    import afilt_pkg::*;
#(
    parameter int BYTES  = 6,
    parameter int BYTE_W = 8,
    localparam int AW    = (BYTES > 1) ? $clog2(BYTES) : 1,
    localparam int CW    = $clog2(BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic [1:0]        acc_mode,
    input  logic              rx_byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_frame_end,
    output logic              accept,
    output logic              reject
);

    logic [BYTES-1:0][BYTE_W-1:0] sta_bytes;
    logic                         byte_take, first_byte, last_byte, end_early;
    logic [CW-1:0]                byte_idx;
    logic                         sta_hit, bc_hit;
    acc_mode_e                    mode_use;

    afilt_station_regs #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_addr),
        .wr_val    (cfg_wdata),
        .sta_bytes (sta_bytes)
    );

    afilt_frame_track #(.BYTES(BYTES)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (rx_byte_vld),
        .frame_end  (rx_frame_end),
        .byte_take  (byte_take),
        .first_byte (first_byte),
        .last_byte  (last_byte),
        .end_early  (end_early),
        .byte_idx   (byte_idx)
    );

    afilt_match #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_take  (byte_take),
        .first_byte (first_byte),
        .byte_idx   (byte_idx),
        .byte_in    (rx_byte),
        .sta_bytes  (sta_bytes),
        .sta_hit    (sta_hit),
        .bc_hit     (bc_hit)
    );

    afilt_decide u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_in    (acc_mode),
        .first_byte (first_byte),
        .last_byte  (last_byte),
        .end_early  (end_early),
        .sta_hit    (sta_hit),
        .bc_hit     (bc_hit),
        .mode_use   (mode_use),
        .accept     (accept),
        .reject     (reject)
    );

endmodule

// File: rtl/afilt_checker.sv
// Module: protocol checker for the receive address filter, bound to the top.
// Assumes the bound signals are the top-level ports plus the frame's mode.
module afilt_checker
    import afilt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_byte_vld,
    input  logic      rx_frame_end,
    input  acc_mode_e mode_use,
    input  logic      accept,
    input  logic      reject
);

    // R7
    dec_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    // R7
    acc_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);

    // R7
    rej_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !reject);

    // R8
    acc_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(rx_byte_vld));

    // R9
    dec_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> $past(rx_byte_vld || rx_frame_end));

    // R3
    none_never_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(mode_use) != ACC_NONE));

    // R6
    all_rej_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && ($past(mode_use) == ACC_ALL)) |-> $past(rx_frame_end));

endmodule

bind rx_addr_filter afilt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_byte_vld  (rx_byte_vld),
    .rx_frame_end (rx_frame_end),
    .mode_use     (mode_use),
    .accept       (accept),
    .reject       (reject)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/100ps
module tb_rx_addr_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] acc_mode = '0;
    logic       rx_byte_vld = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_frame_end = 1'b0;
    logic       accept, reject;

    int n_tests = 0;
    int n_fail  = 0;
    int acc_cnt = 0;
    int rej_cnt = 0;

    always #2.5 clk = ~clk;

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .acc_mode(acc_mode), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_frame_end(rx_frame_end),
        .accept(accept), .reject(reject)
    );

    // Count decision pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            acc_cnt = acc_cnt + int'(accept);
            rej_cnt = rej_cnt + int'(reject);
        end
    end

    localparam logic [47:0] STA_A = 48'h021A3C4D5E6F;
    localparam logic [47:0] REV_A = 48'h6F5E4D3C1A02;
    localparam logic [47:0] OTH_B = 48'h001122334455;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    typedef struct packed {
        logic [1:0]  mode;
        logic [47:0] sta;
        logic [47:0] dest;
        logic        exp_acc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, STA_A, STA_A, 1'b0},                 // R3
        '{2'd0, STA_A, BCAST, 1'b0},                 // R3
        '{2'd1, STA_A, STA_A, 1'b1},                 // R4
        '{2'd1, STA_A, BCAST, 1'b0},                 // R4
        '{2'd1, STA_A, 48'h021A3C4D5E6E, 1'b0},      // R4 last byte off
        '{2'd1, STA_A, 48'h031A3C4D5E6F, 1'b0},      // R4 first byte off
        '{2'd1, STA_A, REV_A, 1'b0},                 // R2 byte order
        '{2'd2, STA_A, STA_A, 1'b1},                 // R5
        '{2'd2, STA_A, BCAST, 1'b1},                 // R5
        '{2'd2, STA_A, 48'hFFFFFFFFFFFE, 1'b0},      // R5 near broadcast
        '{2'd2, STA_A, OTH_B, 1'b0},                 // R5
        '{2'd3, STA_A, OTH_B, 1'b1},                 // R6
        '{2'd3, STA_A, BCAST, 1'b1},                 // R6
        '{2'd1, BCAST, BCAST, 1'b1}                  // R4 station all ones
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic program_station(input logic [47:0] s);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_we    = 1'b1;
            cfg_addr  = 3'(k);
            cfg_wdata = s[47-8*k -: 8];
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_byte(input logic [7:0] b, input bit fe);
        @(negedge clk);
        rx_byte_vld  = 1'b1;
        rx_byte      = b;
        rx_frame_end = fe;
    endtask

    // Send nb bytes of dest; s1 is sampled the cycle after the last byte,
    // s2 the cycle after that (which follows a separate end marker).
    task automatic send_frame(input logic [47:0] dest, input int nb,
                              input bit end_with_last, input int gap,
                              output logic s1a, output logic s1r,
                              output logic s2a, output logic s2r);
        for (int i = 0; i < nb; i++) begin
            if (i > 0 && gap > 0) begin
                @(negedge clk);
                rx_byte_vld  = 1'b0;
                rx_frame_end = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
            drive_byte(dest[47-8*i -: 8], end_with_last && (i == nb - 1));
        end
        @(negedge clk);
        s1a = accept;
        s1r = reject;
        rx_byte_vld  = 1'b0;
        rx_frame_end = !end_with_last;
        @(negedge clk);
        s2a = accept;
        s2r = reject;
        rx_frame_end = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic string req_of(input logic [1:0] m);
        case (m)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic a1, r1, a2, r2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: outputs idle after reset, station bytes cleared
        check(!accept && !reject, "R1", "outputs after reset", {accept, reject}, 0);
        acc_mode = 2'd1;
        send_frame(48'h0, 6, 1'b0, 0, a1, r1, a2, r2);
        check(a1 && !r1, "R1", "zero station accepts zero dest", {a1, r1}, 2);

        // Table walk: R2..R7 across modes and destinations
        for (int v = 0; v < NV; v++) begin
            program_station(VECS[v].sta);
            acc_mode = VECS[v].mode;
            send_frame(VECS[v].dest, 6, 1'b0, 0, a1, r1, a2, r2);
            check((a1 == VECS[v].exp_acc) && (r1 == !VECS[v].exp_acc),
                  req_of(VECS[v].mode), $sformatf("vector %0d decision {acc,rej}", v),
                  {a1, r1}, {VECS[v].exp_acc, !VECS[v].exp_acc});
            check(!a2 && !r2, "R7", $sformatf("vector %0d pulse width", v), {a2, r2}, 0);
        end

        program_station(STA_A);

        // R8: short frame in promiscuous mode, separate end marker
        acc_mode = 2'd3;
        send_frame(OTH_B, 3, 1'b0, 0, a1, r1, a2, r2);
        check(!a1 && !r1 && !a2 && r2, "R8", "3-byte frame",
              {a1, r1, a2, r2}, 1);
        // R8: end marker with fifth byte
        send_frame(OTH_B, 5, 1'b1, 0, a1, r1, a2, r2);
        check(!a1 && r1 && !a2 && !r2, "R8", "5-byte frame end with byte",
              {a1, r1, a2, r2}, 4);
        // R8: empty frame
        send_frame(OTH_B, 0, 1'b0, 0, a1, r1, a2, r2);
        check(!a1 && !r1 && !a2 && r2, "R8", "empty frame",
              {a1, r1, a2, r2}, 1);

        // R9: trailing bytes give no further decision
        acc_cnt = 0;
        rej_cnt = 0;
        for (int i = 0; i < 10; i++) drive_byte(8'(i), 1'b0);
        @(negedge clk);
        rx_byte_vld  = 1'b0;
        rx_frame_end = 1'b1;
        @(negedge clk);
        rx_frame_end = 1'b0;
        repeat (3) @(negedge clk);
        check(acc_cnt == 1 && rej_cnt == 0, "R9", "pulses for 10-byte frame",
              acc_cnt * 10 + rej_cnt, 10);
        acc_mode = 2'd1;
        send_frame(STA_A, 6, 1'b0, 0, a1, r1, a2, r2);
        check(a1 && !r1, "R9", "next frame after trailing bytes", {a1, r1}, 2);

        // R10: mode change mid-frame, station mode to promiscuous
        acc_mode = 2'd1;
        for (int i = 0; i < 6; i++) begin
            if (i == 2) acc_mode = 2'd3;
            drive_byte(OTH_B[47-8*i -: 8], 1'b0);
        end
        @(negedge clk);
        a1 = accept; r1 = reject;
        rx_byte_vld = 1'b0; rx_frame_end = 1'b1;
        @(negedge clk);
        rx_frame_end = 1'b0;
        repeat (2) @(negedge clk);
        check(!a1 && r1, "R10", "mode 1 held after switch to 3", {a1, r1}, 1);
        send_frame(OTH_B, 6, 1'b0, 0, a1, r1, a2, r2);
        check(a1 && !r1, "R10", "mode 3 applies next frame", {a1, r1}, 2);
        // R10: promiscuous to none mid-frame
        acc_mode = 2'd3;
        for (int i = 0; i < 6; i++) begin
            if (i == 4) acc_mode = 2'd0;
            drive_byte(OTH_B[47-8*i -: 8], (i == 5));
        end
        @(negedge clk);
        a1 = accept; r1 = reject;
        rx_byte_vld = 1'b0; rx_frame_end = 1'b0;
        repeat (2) @(negedge clk);
        check(a1 && !r1, "R10", "mode 3 held after switch to 0", {a1, r1}, 2);

        // R11: idle gaps between bytes
        acc_mode = 2'd1;
        send_frame(STA_A, 6, 1'b0, 3, a1, r1, a2, r2);
        check(a1 && !r1 && !a2 && !r2, "R11", "gapped station frame",
              {a1, r1, a2, r2}, 8);

        // R12: end marker with sixth byte, then back-to-back frame
        send_frame(STA_A, 6, 1'b1, 0, a1, r1, a2, r2);
        check(a1 && !r1 && !a2 && !r2, "R12", "end with sixth byte",
              {a1, r1, a2, r2}, 8);
        send_frame(REV_A, 6, 1'b1, 0, a1, r1, a2, r2);
        check(!a1 && r1, "R12", "following frame decided afresh", {a1, r1}, 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule